// File: doc/BRIEF.md
# Lazy-Clear Vector Register File

A small vector register file in which clearing a register costs one cycle and touches no storage. The clear command only raises a per-register pending flag, and every read of a flagged register returns zero. The real zeroing is postponed until software next loads that register. The load writes its elements from index 0 upward, one per beat. If the register was flagged, the positions that load did not reach are then zeroed by a sweep of one element per clock, with `busy_o` high throughout. At the ports this cannot be told apart from a clear that zeroed every element at once.

Each register also carries an in-use bit, which its first load beat sets. A restore command writes a whole register in one cycle, but only when that register's in-use bit is one. Reset zeroes every element and both sets of flags.

Top module: `lazy_vrf`

## Requirements
- R1: After reset, every element of every register reads zero, `in_use_o` is all zeros and `busy_o` is low.
- R2: An accepted clear makes every element of the selected register read zero from the next cycle on, while the stored contents stay as they were.
- R3: A load writes `ld_data_i` to element 0 on its first beat and to the next higher element on each later beat. `ld_reg_i` is taken on the first beat only. The load ends on a beat with `ld_last_i` set, or on the beat that writes the top element.
- R4: A load into a register with a pending clear that ends after c elements, with c below the element count, holds `busy_o` high for exactly (element count - c) cycles after its last beat. It then leaves elements c and above at zero and removes the pending flag.
- R5: A load of all elements into a flagged register, or any load into an unflagged register, never raises `busy_o`.
- R6: Reads of a flagged register during a load or a sweep return the values written so far, and zero everywhere else. Reads always match a model in which a clear zeroes every element at once.
- R7: While `busy_o` is high, load beats are ignored, and clear and restore requests have no effect. A clear still held when `busy_o` falls takes effect then.
- R8: A restore writes element e of the selected register from bits [e*32 +: 32] of `rs_data_i` and removes that register's pending flag, provided its in-use bit is one. If the in-use bit is zero, the restore has no effect.
- R9: The first beat of a load sets bit r of `in_use_o` for the loaded register r. Only reset clears an in-use bit; a clear command does not.
- R10: In an idle cycle a load beat takes priority over a restore, and a restore request takes priority over a clear. Clear and restore are ignored while a load is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clr_valid_i | input | 1 | Clear request |
| clr_reg_i | input | REG_W (4) | Register to clear |
| ld_valid_i | input | 1 | Load beat |
| ld_reg_i | input | REG_W (4) | Load target, sampled on the first beat |
| ld_last_i | input | 1 | Final beat of the load |
| ld_data_i | input | ELEM_W (32) | Element data for this beat |
| rs_valid_i | input | 1 | Restore request |
| rs_reg_i | input | REG_W (4) | Register to restore |
| rs_data_i | input | NUM_ELEMS*ELEM_W (512) | Full register image, element e at bits [e*ELEM_W +: ELEM_W] |
| rd_reg_i | input | REG_W (4) | Read register |
| rd_idx_i | input | IDX_W (4) | Read element index |
| rd_data_o | output | ELEM_W (32) | Read data, combinational |
| busy_o | output | 1 | Deferred zeroing sweep in progress |
| in_use_o | output | NUM_REGS (16) | In-use bit per register |

## Verification
The bench aims at the lazy read paths. It reads a cleared register whose storage still holds data; a design that forgot the mask would return the stale values. It also reads mid-load and mid-sweep, where masking the whole register would hide elements already written, and a missing mask would expose elements not yet zeroed. It covers load lengths of 1, 5, 15 and 16 into flagged registers. Here an off-by-one in the sweep pointer shows up as a wrong `busy_o` length or as a leftover nonzero element. Clears, restores and loads that arrive during a sweep or a load, and restores of registers whose in-use bit is clear, catch a design that lets them through; it would corrupt another register, drop the held clear, or validate a register that was never loaded.

// File: rtl/lazy_vrf_pkg.sv
package lazy_vrf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SWEEP = 2'd2
  } seq_state_e;
endpackage

// File: rtl/vrf_seq.sv
module vrf_seq
  import lazy_vrf_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int NUM_ELEMS = 16,
  localparam int REG_W = $clog2(NUM_REGS),
  localparam int IDX_W = $clog2(NUM_ELEMS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ld_valid_i,
  input  logic [REG_W-1:0]    ld_reg_i,
  input  logic                ld_last_i,
  input  logic [NUM_REGS-1:0] pend_i,
  output seq_state_e          state_o,
  output logic [REG_W-1:0]    live_reg_o,
  output logic [IDX_W-1:0]    ptr_o,
  output logic                wr_en_o,
  output logic                wr_zero_o,
  output logic [REG_W-1:0]    wr_reg_o,
  output logic [IDX_W-1:0]    wr_idx_o,
  output logic                ld_beat_o,
  output logic                done_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ELEMS - 1);

  seq_state_e       st_q, st_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [REG_W-1:0] live_q, live_d;
  logic [IDX_W-1:0] cur_idx;

  assign cur_idx  = (st_q == ST_LOAD) ? ptr_q : '0;
  assign wr_reg_o = (st_q == ST_IDLE) ? ld_reg_i : live_q;
  assign wr_idx_o = (st_q == ST_IDLE) ? '0 : ptr_q;

  always_comb begin
    st_d      = st_q;
    ptr_d     = ptr_q;
    live_d    = live_q;
    wr_en_o   = 1'b0;
    wr_zero_o = 1'b0;
    ld_beat_o = 1'b0;
    done_o    = 1'b0;
    case (st_q)
      ST_IDLE, ST_LOAD: begin
        if (ld_valid_i) begin
          ld_beat_o = 1'b1;
          wr_en_o   = 1'b1;
          if (st_q == ST_IDLE) live_d = ld_reg_i;
          if (ld_last_i || cur_idx == LAST_IDX) begin
            if (pend_i[wr_reg_o] && cur_idx != LAST_IDX) begin
              st_d  = ST_SWEEP;
              ptr_d = cur_idx + IDX_W'(1);
            end else begin
              done_o = pend_i[wr_reg_o];
              st_d   = ST_IDLE;
              ptr_d  = '0;
            end
          end else begin
            st_d  = ST_LOAD;
            ptr_d = cur_idx + IDX_W'(1);
          end
        end
      end
      ST_SWEEP: begin
        wr_en_o   = 1'b1;
        wr_zero_o = 1'b1;
        if (ptr_q == LAST_IDX) begin
          done_o = 1'b1;
          st_d   = ST_IDLE;
          ptr_d  = '0;
        end else begin
          ptr_d = ptr_q + IDX_W'(1);
        end
      end
      default: begin
        st_d  = ST_IDLE;
        ptr_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ptr_q  <= '0;
      live_q <= '0;
    end else begin
      st_q   <= st_d;
      ptr_q  <= ptr_d;
      live_q <= live_d;
    end
  end

  assign state_o    = st_q;
  assign live_reg_o = live_q;
  assign ptr_o      = ptr_q;
endmodule

// File: rtl/vrf_flags.sv
module vrf_flags #(
  parameter int NUM_REGS = 16,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mark_i,
  input  logic [REG_W-1:0]    mark_reg_i,
  input  logic                drop_i,
  input  logic [REG_W-1:0]    drop_reg_i,
  input  logic                use_i,
  input  logic [REG_W-1:0]    use_reg_i,
  output logic [NUM_REGS-1:0] pend_o,
  output logic [NUM_REGS-1:0] in_use_o
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_o[r]   <= 1'b0;
        in_use_o[r] <= 1'b0;
      end else begin
        if (mark_i && mark_reg_i == REG_W'(r))      pend_o[r] <= 1'b1;
        else if (drop_i && drop_reg_i == REG_W'(r)) pend_o[r] <= 1'b0;
        if (use_i && use_reg_i == REG_W'(r))        in_use_o[r] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vrf_store.sv
module vrf_store #(
  parameter int NUM_REGS  = 16,
  parameter int NUM_ELEMS = 16,
  parameter int ELEM_W    = 32,
  localparam int REG_W = $clog2(NUM_REGS),
  localparam int IDX_W = $clog2(NUM_ELEMS),
  localparam int VEC_W = NUM_ELEMS * ELEM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_reg_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ELEM_W-1:0] wr_data_i,
  input  logic              rs_en_i,
  input  logic [REG_W-1:0]  rs_reg_i,
  input  logic [VEC_W-1:0]  rs_data_i,
  input  logic [REG_W-1:0]  rd_reg_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [ELEM_W-1:0] rd_data_o
);
  logic [ELEM_W-1:0] mem_q [NUM_REGS][NUM_ELEMS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NUM_REGS; r++)
        for (int e = 0; e < NUM_ELEMS; e++)
          mem_q[r][e] <= '0;
    end else begin
      for (int r = 0; r < NUM_REGS; r++)
        for (int e = 0; e < NUM_ELEMS; e++)
          if (wr_en_i && wr_reg_i == REG_W'(r) && wr_idx_i == IDX_W'(e))
            mem_q[r][e] <= wr_data_i;
          else if (rs_en_i && rs_reg_i == REG_W'(r))
            mem_q[r][e] <= rs_data_i[e*ELEM_W +: ELEM_W];
    end
  end

  assign rd_data_o = mem_q[rd_reg_i][rd_idx_i];
endmodule

// File: rtl/lazy_vrf.sv
module lazy_vrf
  import lazy_vrf_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int NUM_ELEMS = 16,
  parameter int ELEM_W    = 32,
  localparam int REG_W = $clog2(NUM_REGS),
  localparam int IDX_W = $clog2(NUM_ELEMS),
  localparam int VEC_W = NUM_ELEMS * ELEM_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_valid_i,
  input  logic [REG_W-1:0]    clr_reg_i,
  input  logic                ld_valid_i,
  input  logic [REG_W-1:0]    ld_reg_i,
  input  logic                ld_last_i,
  input  logic [ELEM_W-1:0]   ld_data_i,
  input  logic                rs_valid_i,
  input  logic [REG_W-1:0]    rs_reg_i,
  input  logic [VEC_W-1:0]    rs_data_i,
  input  logic [REG_W-1:0]    rd_reg_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [ELEM_W-1:0]   rd_data_o,
  output logic                busy_o,
  output logic [NUM_REGS-1:0] in_use_o
);
  seq_state_e          st;
  logic [REG_W-1:0]    live_reg, wr_reg;
  logic [IDX_W-1:0]    ptr, wr_idx;
  logic                wr_en, wr_zero, ld_beat, done;
  logic [NUM_REGS-1:0] pend;
  logic                cmd_idle, clr_acc, rs_acc, live_cover;
  logic [ELEM_W-1:0]   raw_data;

  assign cmd_idle = (st == ST_IDLE);
  // load beats outrank restore requests, which outrank clears
  assign rs_acc  = cmd_idle && !ld_valid_i && rs_valid_i && in_use_o[rs_reg_i];
  assign clr_acc = cmd_idle && !ld_valid_i && !rs_valid_i && clr_valid_i;

  vrf_seq #(.NUM_REGS(NUM_REGS), .NUM_ELEMS(NUM_ELEMS)) u_seq (
    .clk_i, .rst_ni,
    .ld_valid_i, .ld_reg_i, .ld_last_i,
    .pend_i     (pend),
    .state_o    (st),
    .live_reg_o (live_reg),
    .ptr_o      (ptr),
    .wr_en_o    (wr_en),
    .wr_zero_o  (wr_zero),
    .wr_reg_o   (wr_reg),
    .wr_idx_o   (wr_idx),
    .ld_beat_o  (ld_beat),
    .done_o     (done)
  );

  vrf_flags #(.NUM_REGS(NUM_REGS)) u_flags (
    .clk_i, .rst_ni,
    .mark_i     (clr_acc),
    .mark_reg_i (clr_reg_i),
    .drop_i     (done | rs_acc),
    .drop_reg_i (done ? wr_reg : rs_reg_i),
    .use_i      (ld_beat),
    .use_reg_i  (wr_reg),
    .pend_o     (pend),
    .in_use_o   (in_use_o)
  );

  vrf_store #(.NUM_REGS(NUM_REGS), .NUM_ELEMS(NUM_ELEMS), .ELEM_W(ELEM_W)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i   (wr_en),
    .wr_reg_i  (wr_reg),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_zero ? '0 : ld_data_i),
    .rs_en_i   (rs_acc),
    .rs_reg_i,
    .rs_data_i,
    .rd_reg_i,
    .rd_idx_i,
    .rd_data_o (raw_data)
  );

  // below ptr the live register already holds loaded or swept values
  assign live_cover = !cmd_idle && rd_reg_i == live_reg && rd_idx_i < ptr;
  assign rd_data_o  = (pend[rd_reg_i] && !live_cover) ? '0 : raw_data;
  assign busy_o     = (st == ST_SWEEP);
endmodule

// File: rtl/lazy_vrf_chk.sv
module lazy_vrf_chk #(
  parameter int NUM_REGS  = 16,
  parameter int NUM_ELEMS = 16,
  parameter int ELEM_W    = 32,
  localparam int REG_W = $clog2(NUM_REGS),
  localparam int IDX_W = $clog2(NUM_ELEMS),
  localparam int VEC_W = NUM_ELEMS * ELEM_W
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                idle_i,
  input logic                ld_valid_i,
  input logic                clr_valid_i,
  input logic [REG_W-1:0]    clr_reg_i,
  input logic                rs_valid_i,
  input logic [REG_W-1:0]    rs_reg_i,
  input logic [VEC_W-1:0]    rs_data_i,
  input logic [REG_W-1:0]    rd_reg_i,
  input logic [IDX_W-1:0]    rd_idx_i,
  input logic [ELEM_W-1:0]   rd_data_o,
  input logic                busy_o,
  input logic [NUM_REGS-1:0] in_use_o
);
  function automatic logic [ELEM_W-1:0] elem_at(logic [VEC_W-1:0] v, logic [IDX_W-1:0] i);
    return v[i*ELEM_W +: ELEM_W];
  endfunction

  p_clear_reads_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && clr_valid_i && !ld_valid_i && !rs_valid_i)
    |=> (rd_reg_i != $past(clr_reg_i)) || (rd_data_o == '0));

  p_sweep_after_beat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(ld_valid_i));

  p_busy_keeps_inuse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(in_use_o));

  p_restore_writes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && !ld_valid_i && rs_valid_i && in_use_o[rs_reg_i])
    |=> (rd_reg_i != $past(rs_reg_i)) || (rd_data_o == elem_at($past(rs_data_i), rd_idx_i)));

  p_inuse_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_use_o & $past(in_use_o)) == $past(in_use_o));
endmodule

bind lazy_vrf lazy_vrf_chk #(
  .NUM_REGS(NUM_REGS), .NUM_ELEMS(NUM_ELEMS), .ELEM_W(ELEM_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .idle_i      (cmd_idle),
  .ld_valid_i  (ld_valid_i),
  .clr_valid_i (clr_valid_i),
  .clr_reg_i   (clr_reg_i),
  .rs_valid_i  (rs_valid_i),
  .rs_reg_i    (rs_reg_i),
  .rs_data_i   (rs_data_i),
  .rd_reg_i    (rd_reg_i),
  .rd_idx_i    (rd_idx_i),
  .rd_data_o   (rd_data_o),
  .busy_o      (busy_o),
  .in_use_o    (in_use_o)
);

// File: tb/lazy_vrf_tb.sv
`timescale 1ns/1ps
module lazy_vrf_tb;
  localparam int NR = 16;
  localparam int NE = 16;
  localparam int EW = 32;
  localparam int RW = $clog2(NR);
  localparam int IW = $clog2(NE);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr_valid = 0, ld_valid = 0, ld_last = 0, rs_valid = 0;
  logic [RW-1:0] clr_reg = '0, ld_reg = '0, rs_reg = '0, rd_reg = '0;
  logic [IW-1:0] rd_idx = '0;
  logic [EW-1:0] ld_data = '0;
  logic [NE*EW-1:0] rs_data = '0;
  logic [EW-1:0] rd_data;
  logic          busy;
  logic [NR-1:0] in_use;

  always #2.5 clk = ~clk;

  lazy_vrf u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .clr_valid_i(clr_valid), .clr_reg_i(clr_reg),
    .ld_valid_i(ld_valid), .ld_reg_i(ld_reg), .ld_last_i(ld_last), .ld_data_i(ld_data),
    .rs_valid_i(rs_valid), .rs_reg_i(rs_reg), .rs_data_i(rs_data),
    .rd_reg_i(rd_reg), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .busy_o(busy), .in_use_o(in_use)
  );

  // reference: a clear zeroes the logical contents at once
  logic [EW-1:0] lval [NR][NE];
  logic [NR-1:0] m_pend = '0, m_use = '0;
  bit            m_loading = 0;
  int            m_lreg = 0, m_lptr = 0, m_sweep = 0, m_sreg = 0;
  int            n_vec = 0, n_bad = 0;
  string         tag = "R1";
  bit            done_flag = 0;

  initial for (int r = 0; r < NR; r++) for (int e = 0; e < NE; e++) lval[r][e] = '0;

  task automatic model_step();
    int r;
    if (m_sweep > 0) begin
      m_sweep--;
      if (m_sweep == 0) m_pend[m_sreg] = 1'b0;
    end else if (ld_valid) begin
      r = m_loading ? m_lreg : int'(ld_reg);
      lval[r][m_lptr] = ld_data;
      m_use[r] = 1'b1;
      if (ld_last || m_lptr == NE-1) begin
        if (m_pend[r]) begin
          if (m_lptr == NE-1) m_pend[r] = 1'b0;
          else begin m_sweep = NE-1-m_lptr; m_sreg = r; end
        end
        m_loading = 0; m_lptr = 0;
      end else begin
        m_loading = 1; m_lreg = r; m_lptr++;
      end
    end else if (m_loading) begin
      // clear and restore are held off mid-load
    end else if (rs_valid) begin
      if (m_use[rs_reg]) begin
        for (int e = 0; e < NE; e++) lval[rs_reg][e] = rs_data[e*EW +: EW];
        m_pend[rs_reg] = 1'b0;
      end
    end else if (clr_valid) begin
      for (int e = 0; e < NE; e++) lval[clr_reg][e] = '0;
      m_pend[clr_reg] = 1'b1;
    end
  endtask

  task automatic compare();
    logic [EW-1:0] exp_d;
    exp_d = lval[rd_reg][rd_idx];
    n_vec++;
    if (rd_data !== exp_d || busy !== (m_sweep > 0) || in_use !== m_use) begin
      n_bad++;
      $display("FAIL %s r%0d[%0d] rd_data act=%h exp=%h busy act=%b exp=%b in_use act=%h exp=%h",
               tag, rd_reg, rd_idx, rd_data, exp_d, busy, (m_sweep > 0), in_use, m_use);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) model_step();
    #1;
    if (rst_n) compare();
  endtask

  task automatic scan(input int r);
    for (int e = 0; e < NE; e++) begin
      rd_reg = RW'(r); rd_idx = IW'(e); tick();
    end
  endtask

  task automatic do_load(input int r, input int cnt, input logic [EW-1:0] base);
    for (int i = 0; i < cnt; i++) begin
      ld_valid = 1; ld_reg = RW'(r); ld_last = (i == cnt-1); ld_data = base + EW'(i);
      rd_reg = RW'(r); rd_idx = IW'(i); tick();
    end
    ld_valid = 0; ld_last = 0;
  endtask

  task automatic do_clear(input int r);
    clr_valid = 1; clr_reg = RW'(r); tick(); clr_valid = 0;
  endtask

  task automatic do_restore(input int r, input logic [EW-1:0] seed);
    rs_valid = 1; rs_reg = RW'(r);
    for (int e = 0; e < NE; e++) rs_data[e*EW +: EW] = seed ^ EW'(e * 32'h0101_0101);
    tick(); rs_valid = 0;
  endtask

  task automatic watch(input int r, input int n);
    for (int i = 0; i < n; i++) begin
      rd_reg = RW'(r); rd_idx = IW'(i % NE); tick();
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tag = "R1";
    for (int r = 0; r < NR; r++) scan(r);

    tag = "R3";
    for (int r = 0; r < 4; r++) do_load(r, NE, 32'hA000_0000 + (r << 8));
    for (int r = 0; r < 4; r++) scan(r);
    tag = "R9";
    scan(4);

    tag = "R2";  // storage of reg1 still holds data
    do_clear(1); scan(1);
    tag = "R4";
    do_load(1, 5, 32'hB100_0000); watch(1, 14); scan(1);
    tag = "R5";
    do_clear(2); scan(2); do_load(2, NE, 32'hC200_0000); watch(2, 3); scan(2);
    tag = "R4";
    do_clear(3); do_load(3, 15, 32'hD300_0000); watch(3, 3); scan(3);
    do_clear(3); do_load(3, 1, 32'hD400_0000); watch(3, 17);

    tag = "R8";
    do_clear(0); do_restore(0, 32'h5A5A_0000); scan(0);
    do_clear(7); do_restore(7, 32'h1234_0000); scan(7);

    tag = "R7";  // clear, load and restore during a sweep
    do_clear(0); do_load(0, 2, 32'hE000_0000);
    clr_valid = 1; clr_reg = 2;
    ld_valid = 1; ld_reg = 6; ld_last = 1; ld_data = 32'hDEAD_BEEF;
    rd_reg = 2; rd_idx = 4; tick();
    ld_valid = 0; ld_last = 0;
    rs_valid = 1; rs_reg = 3; rs_data = '1;
    for (int i = 0; i < 16; i++) begin rd_idx = IW'(i); rd_reg = (i % 2) ? 2 : 6; tick(); end
    rs_valid = 0; clr_valid = 0;
    scan(2); scan(3); scan(6); scan(0);

    tag = "R10";
    ld_valid = 1; ld_reg = 5; ld_last = 0; ld_data = 32'h0F0F_0001;
    rs_valid = 1; rs_reg = 0; clr_valid = 1; clr_reg = 0; tick();
    ld_data = 32'h0F0F_0002; ld_reg = 9; tick();
    ld_data = 32'h0F0F_0003; ld_last = 1; tick();
    ld_valid = 0; ld_last = 0; rs_valid = 0;
    tick(); clr_valid = 0;
    scan(5); scan(0); scan(9);

    tag = "R6";
    for (int i = 0; i < 4000; i++) begin
      int unsigned x;
      x = $urandom;
      ld_valid  = (x[2:0] < 3);
      ld_reg    = RW'($urandom);
      ld_last   = (x[5:4] == 0);
      ld_data   = $urandom;
      clr_valid = (x[9:7] == 0);
      clr_reg   = RW'($urandom);
      rs_valid  = (x[13:10] == 0);
      rs_reg    = RW'($urandom);
      for (int e = 0; e < NE; e++) rs_data[e*EW +: EW] = $urandom;
      rd_reg    = (x[14]) ? RW'(m_sreg) : RW'($urandom);
      rd_idx    = IW'($urandom);
      tick();
    end
    ld_valid = 0; clr_valid = 0; rs_valid = 0; ld_last = 0;
    watch(0, 20);
    for (int r = 0; r < NR; r++) scan(r);

    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #900000;
    if (!done_flag) begin
      done_flag = 1;
      n_bad++;
      $display("FAIL watchdog %s act=timeout exp=completion", tag);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule